// File: doc/BRIEF.md
# Serial Control Register Loader

This block is a write-only serial slave that fills a small bank of 8-bit control registers from a four-wire style link: an active-low select, a serial clock and a serial data input. All logic runs on a fast system clock. The three serial pins are passed through two-flop synchronisers, and the rising edge of the serial clock is found by edge detection. The serial clock must therefore be slower than about a quarter of the system clock rate.

Each transaction opens with an identification byte: a fixed 7-bit device code followed by a direction bit. A pointer byte comes next. Its low seven bits name the target register and its top bit selects stepping mode. Data bytes follow. In stepping mode the pointer advances by one after each data byte. Otherwise every data byte goes to the same register. Registers are published as one flat parallel bus, with a one-cycle strobe per register. The strobes cannot be held off: a consumer that needs the value must take it in the strobe cycle. The bus always holds the latest value, so there is no back-pressure path.

Top module: `spi_reg_loader`

## Requirements
- R1: After reset every register reads 0 on `regs_flat` and no bit of `wr_stb` is set.
- R2: The first byte of a transaction is accepted only when its bits 7:1 equal `CHIP_ID` (default 7'b0010000) and bit 0 is 0. Any other value makes the block ignore every further byte until select goes high.
- R3: A first byte with the correct device code and bit 0 = 1 (a read request) changes no register and raises no strobe.
- R4: Every byte is received most significant bit first, one bit per rising serial clock edge while select is low.
- R5: In the second byte, bits 6:0 give the starting register pointer and bit 7 is the stepping flag.
- R6: With the stepping flag at 0, every data byte is written to the same register, and the last byte wins.
- R7: With the stepping flag at 1, the pointer advances by one after each data byte and wraps from 127 to 0.
- R8: A data byte aimed at a pointer of `NUM_REGS` or above, or at a register marked in `RSVD_MASK` (default registers 0 and 6), is discarded. Such a register stays 0 and never strobes.
- R9: Select going high discards a partly received byte, and the next transaction starts again with the identification byte.
- R10: Each accepted data byte produces exactly one single-cycle pulse on its register's `wr_stb` bit, in the same cycle the new value appears on `regs_flat`. Registers change in no other cycle.
- R11: When select rises in the same system cycle as the eighth rising serial clock edge of a byte, that byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low transaction select (asynchronous) |
| spi_sclk | input | 1 | Serial clock, data sampled on its rising edge (asynchronous) |
| spi_mosi | input | 1 | Serial data in (asynchronous) |
| regs_flat | output | NUM_REGS*8 | Register bank, register i in bits 8i+7:8i |
| wr_stb | output | NUM_REGS | One-cycle write pulse per register |

## Verification
Select deassertion and completion of a byte can land in the same system cycle. The bench provokes this by raising select and the serial clock on the same system clock edge for the eighth bit of a data byte. Both pins pass through synchronisers of equal depth, so the two events meet inside the block. The bench then expects the earlier bytes of that burst to be written and the clipped byte to leave its target register and strobe count untouched.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    PH_CHIP = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign d_sync = stage2;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_reg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sel,
  input  logic  bit_stb,
  input  logic  din,
  output logic  byte_vld,
  output byte_t byte_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              last_bit;

  assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (bit_stb) begin
        shreg   <= {shreg[BYTE_W-3:0], din};
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (last_bit) begin
          byte_vld <= 1'b1;
          byte_q   <= {shreg, din};
        end
      end
    end
  end
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_reg_pkg::*;
#(
  parameter logic [6:0] CHIP_ID = 7'b0010000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             byte_vld,
  input  byte_t            byte_q,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output byte_t            wr_data
);
  phase_t           phase_q, phase_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             step_q, step_d;
  logic             id_ok;

  assign id_ok   = (byte_q[BYTE_W-1:1] == CHIP_ID) && !byte_q[0];
  assign wr_en   = byte_vld && (phase_q == PH_DATA);
  assign wr_ptr  = ptr_q;
  assign wr_data = byte_q;

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    step_d  = step_q;
    if (byte_vld) begin
      unique case (phase_q)
        PH_CHIP: phase_d = id_ok ? PH_PTR : PH_SKIP;
        PH_PTR: begin
          ptr_d   = byte_q[PTR_W-1:0];
          step_d  = byte_q[BYTE_W-1];
          phase_d = PH_DATA;
        end
        PH_DATA: if (step_q) ptr_d = ptr_q + 1'b1;
        PH_SKIP: phase_d = PH_SKIP;
      endcase
    end
    if (!sel) phase_d = PH_CHIP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CHIP;
      ptr_q   <= '0;
      step_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
      step_q  <= step_d;
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int                NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] RSVD_MASK = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_ptr,
  input  byte_t                      wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat,
  output logic [NUM_REGS-1:0]        wr_stb
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (RSVD_MASK[i]) begin : g_rsvd
      assign regs_flat[i*BYTE_W +: BYTE_W] = '0;
      assign wr_stb[i] = 1'b0;
    end else begin : g_live
      byte_t value_q;
      logic  stb_q;
      logic  hit;
      assign hit = wr_en && (wr_ptr == PTR_W'(i));
      always_ff @(posedge clk) begin
        if (rst) begin
          value_q <= '0;
          stb_q   <= 1'b0;
        end else begin
          stb_q <= hit;
          if (hit) value_q <= wr_data;
        end
      end
      assign regs_flat[i*BYTE_W +: BYTE_W] = value_q;
      assign wr_stb[i] = stb_q;
    end
  end
endmodule

// File: rtl/spi_reg_loader.sv
module spi_reg_loader
  import spi_reg_pkg::*;
#(
  parameter int                  NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] RSVD_MASK = 8'b0100_0001,
  parameter logic [6:0]          CHIP_ID   = 7'b0010000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       spi_cs_n,
  input  logic                       spi_sclk,
  input  logic                       spi_mosi,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat,
  output logic [NUM_REGS-1:0]        wr_stb
);
  logic [2:0]       pins_sync;
  logic             sclk_prev;
  logic             sclk_rise;
  logic             sel;
  logic             byte_vld;
  byte_t            byte_q;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  byte_t            wr_data;

  spi_pin_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({spi_cs_n, spi_sclk, spi_mosi}),
    .d_sync  (pins_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= pins_sync[1];
  end

  assign sel       = !pins_sync[2];
  assign sclk_rise = pins_sync[1] && !sclk_prev;

  spi_byte_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .bit_stb  (sclk_rise),
    .din      (pins_sync[0]),
    .byte_vld (byte_vld),
    .byte_q   (byte_q)
  );

  spi_txn_ctrl #(.CHIP_ID(CHIP_ID)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .byte_vld (byte_vld),
    .byte_q   (byte_q),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .wr_data  (wr_data)
  );

  spi_reg_bank #(.NUM_REGS(NUM_REGS), .RSVD_MASK(RSVD_MASK)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .regs_flat (regs_flat),
    .wr_stb    (wr_stb)
  );
endmodule

// File: rtl/spi_reg_loader_chk.sv
module spi_reg_loader_chk #(
  parameter int                  NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] RSVD_MASK = '0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  spi_cs_n,
  input logic [NUM_REGS*8-1:0] regs_flat,
  input logic [NUM_REGS-1:0]   wr_stb
);
  logic [2:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !spi_cs_n)   idle_cnt <= '0;
    else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 1'b1;
  end

  // R10: at most one register strobes in a cycle
  p_stb_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb));

  // R10: a strobe lasts a single cycle
  p_stb_single_r10: assert property (@(posedge clk) disable iff (rst)
    (|wr_stb) |=> !(|wr_stb));

  // R10: register contents only move alongside a strobe
  p_no_silent_change_r10: assert property (@(posedge clk) disable iff (rst)
    !(|wr_stb) |-> $stable(regs_flat));

  // R9: a long idle select produces no writes
  p_idle_no_stb_r9: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= 3'd6) |-> (wr_stb == '0));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rsvd_chk
    if (RSVD_MASK[g]) begin : g_on
      // R8: reserved registers stay zero and never strobe
      p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (regs_flat[g*8 +: 8] == 8'h00) && !wr_stb[g]);
    end
  end
endmodule

bind spi_reg_loader spi_reg_loader_chk #(
  .NUM_REGS (NUM_REGS),
  .RSVD_MASK(RSVD_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .spi_cs_n  (spi_cs_n),
  .regs_flat (regs_flat),
  .wr_stb    (wr_stb)
);

// File: tb/spi_reg_loader_bench.sv
module spi_reg_loader_bench;
  localparam int         NR   = 8;
  localparam logic [7:0] RSVD = 8'b0100_0001;
  localparam logic [7:0] ID_W = 8'h20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b0;
  logic          mosi = 1'b0;
  logic [NR*8-1:0] regs_flat;
  logic [NR-1:0]   wr_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_val [NR];
  int         exp_cnt [NR];
  int         got_cnt [NR];
  logic [7:0] dbuf [8];

  always #2.5 clk = ~clk;

  spi_reg_loader u_spi_reg_loader (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .regs_flat(regs_flat), .wr_stb(wr_stb)
  );

  always @(negedge clk) begin
    if (!rst)
      for (int i = 0; i < NR; i++) if (wr_stb[i]) got_cnt[i]++;
  end

  task automatic check_all(input string tag);
    bit bad = 1'b0;
    checks++;
    for (int i = 0; i < NR; i++) begin
      if (!bad && (regs_flat[i*8 +: 8] !== exp_val[i] || got_cnt[i] != exp_cnt[i])) begin
        bad = 1'b1;
        errors++;
        $display("FAIL %s reg%0d: value %h strobes %0d, expected value %h strobes %0d",
                 tag, i, regs_flat[i*8 +: 8], got_cnt[i], exp_val[i], exp_cnt[i]);
      end
    end
  endtask

  task automatic bits_out(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      mosi = b[7-i];
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic cs_open();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_close();
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  // model: writes the first n entries of dbuf
  task automatic model_txn(input logic [7:0] idb, input logic [7:0] mapb, input int n);
    int p;
    if (idb != ID_W) return;
    p = int'(mapb[6:0]);
    for (int k = 0; k < n; k++) begin
      if (p < NR && !RSVD[p]) begin
        exp_val[p] = dbuf[k];
        exp_cnt[p]++;
      end
      if (mapb[7]) p = (p + 1) % 128;
    end
  endtask

  task automatic full_txn(input logic [7:0] idb, input logic [7:0] mapb, input int n);
    cs_open();
    bits_out(idb, 8);
    bits_out(mapb, 8);
    for (int k = 0; k < n; k++) bits_out(dbuf[k], 8);
    cs_close();
    model_txn(idb, mapb, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      exp_val[i] = 8'h00; exp_cnt[i] = 0; got_cnt[i] = 0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check_all("R1 reset");

    // R4: bit order
    dbuf[0] = 8'h01; full_txn(ID_W, 8'h01, 1); check_all("R4 lsb set");
    dbuf[0] = 8'h80; full_txn(ID_W, 8'h02, 1); check_all("R4 msb set");

    // R5 R6 R7 R8: pointer sweep in both modes
    for (int inc = 0; inc < 2; inc++) begin
      for (int p = 0; p < 10; p++) begin
        for (int k = 0; k < 3; k++) dbuf[k] = 8'(p * 29 + k * 71 + inc * 13 + 7);
        full_txn(ID_W, {inc[0], 7'(p)}, 3);
        check_all(inc != 0 ? "R7 stepping sweep" : "R6 fixed sweep");
      end
    end

    // R7: wrap 127 -> 0 -> 1
    dbuf[0] = 8'hA1; dbuf[1] = 8'hB2; dbuf[2] = 8'hC3;
    full_txn(ID_W, 8'hFF, 3);
    check_all("R7 wrap");

    // R3: read request
    dbuf[0] = 8'h55; dbuf[1] = 8'h66;
    full_txn(ID_W | 8'h01, 8'h82, 2);
    check_all("R3 read ignored");

    // R2: every other identification byte
    for (int a = 0; a < 256; a++) begin
      if (8'(a) == ID_W) continue;
      dbuf[0] = 8'(a ^ 8'h3C); dbuf[1] = 8'(a + 8'h11);
      full_txn(8'(a), 8'h83, 2);
      check_all("R2 id mismatch");
    end

    // R9: abort inside a data byte
    cs_open(); bits_out(ID_W, 8); bits_out(8'h03, 8); bits_out(8'hE7, 5); cs_close();
    check_all("R9 abort data");
    // R9: abort inside the id byte, then a clean transaction
    cs_open(); bits_out(ID_W, 3); cs_close();
    dbuf[0] = 8'h9D; full_txn(ID_W, 8'h04, 1);
    check_all("R9 restart");

    // R11: select rises with the eighth edge of the second data byte
    cs_open(); bits_out(ID_W, 8); bits_out(8'h82, 8); bits_out(8'h4B, 8);
    bits_out(8'hD2, 7);
    mosi = 1'b0; sclk = 1'b0; repeat (4) @(negedge clk);
    sclk = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (24) @(negedge clk);
    dbuf[0] = 8'h4B; model_txn(ID_W, 8'h82, 1);
    check_all("R11 clipped byte");

    // R10: back-to-back strobe counts on a single register
    for (int k = 0; k < 6; k++) dbuf[k] = 8'(k * 41 + 3);
    full_txn(ID_W, 8'h05, 6);
    check_all("R10 repeated strobes");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule